// File: doc/BRIEF.md
# Partition power-up sequencer

This block brings a single switchable power partition from the off state to a running state in a fixed, safe order. A one-cycle `start` launches the sequence. The block holds the partition in reset and stops its clock. It then asks the power controller for power and waits for power-good. Next it enables the clock and lets it run for a settle time. After that it asks the isolation logic to drop the clamps, and it releases reset last. The outcome is reported as a one-cycle `done` or `error` pulse.

Both external handshakes use a level request that stays high until its acknowledge arrives or a timeout expires. A failure rolls the partition back to a safe off state, and the rollback depends on how far the sequence got. If the clock had not yet been enabled, the block re-asserts reset and pulses a power-off request. If the clock was already running, the block first stops the clock and then does the same. When the partition already reports power-good at the start, no power request is made and the sequence goes straight to the clock-enable step. The settle time and both timeouts are parameters counted in clock cycles.

Top module: `part_pwrup_seq`

## Requirements
- R1: After reset, `part_rst` is 1 and `part_clk_en`, `pwr_req`, `clamp_req`, `pwr_off`, `busy`, `done` and `error` are all 0.
- R2: One cycle after an accepted `start`, `part_rst` is 1 and `busy` is 1. One cycle later `part_clk_en` is 0. `pwr_req` is never 1 while `part_clk_en` is 1.
- R3: `pwr_req` stays high until `pwr_good` is seen. If `pwr_good` never arrives, `pwr_req` is high for exactly `PWR_TMO` cycles.
- R4: `part_clk_en` rises two cycles after `pwr_good` rises. `clamp_req` rises exactly `SETTLE_CYC` cycles after `part_clk_en` rises.
- R5: `clamp_req` stays high until `clamp_ack`. The cycle in which `done` is high shows `part_rst` at 0, `part_clk_en` at 1 and `clamp_req` at 0.
- R6: `done` and `error` are single-cycle pulses and are never high together. Each accepted start yields exactly one of them.
- R7: On a power timeout, `error` pulses together with `part_rst`=1 and a one-cycle `pwr_off`. `part_clk_en` is never enabled during that attempt.
- R8: On a clamp timeout, `clamp_req` has been high for exactly `CLAMP_TMO` cycles. `part_clk_en` then falls one cycle before `error` pulses together with `part_rst`=1 and `pwr_off`=1.
- R9: A `start` that arrives while `busy` is 1 is ignored: it yields no extra result.
- R10: If `pwr_good` is already 1 when the sequence reaches the power step, `pwr_req` is never raised and the sequence still completes with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to power up the partition |
| pwr_good | input | 1 | Partition power is on |
| clamp_ack | input | 1 | Isolation clamps have been removed |
| part_rst | output | 1 | Partition reset, active high |
| part_clk_en | output | 1 | Partition clock enable |
| pwr_req | output | 1 | Power-on request, held until power-good or timeout |
| pwr_off | output | 1 | One-cycle power-off request during rollback |
| clamp_req | output | 1 | Clamp-removal request, held until ack or timeout |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: partition is up |
| error | output | 1 | One-cycle pulse: sequence failed and was rolled back |

## Verification
Two things can land in the same cycle. The first is a fresh `start` landing on a cycle where the sequencer is still busy. The bench raises a second start two cycles into a run and then confirms that the scoreboard receives exactly one result for that run. The second is a rollback step landing together with the outcome pulse. The bench samples `part_rst`, `pwr_off` and `part_clk_en` in the very cycle `error` or `done` is seen, and compares them with what the requirements say that cycle must show.

// File: rtl/part_pwrup_seq.sv
module part_pwrup_seq #(
  parameter int SETTLE_CYC = 2500,
  parameter int PWR_TMO    = 12500,
  parameter int CLAMP_TMO  = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pwr_good,
  input  logic clamp_ack,
  output logic part_rst,
  output logic part_clk_en,
  output logic pwr_req,
  output logic pwr_off,
  output logic clamp_req,
  output logic busy,
  output logic done,
  output logic error
);
  localparam int MAX_A = (SETTLE_CYC > PWR_TMO) ? SETTLE_CYC : PWR_TMO;
  localparam int MAX_V = (MAX_A > CLAMP_TMO) ? MAX_A : CLAMP_TMO;
  localparam int CW    = $clog2(MAX_V + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CLKSTOP, S_PWR, S_CLKON, S_SETTLE,
    S_UNCLAMP, S_RELEASE, S_UNDO_CLK, S_UNDO_PWR
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      part_rst    <= 1'b1;
      part_clk_en <= 1'b0;
      pwr_req     <= 1'b0;
      pwr_off     <= 1'b0;
      clamp_req   <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
    end else begin
      done    <= 1'b0;
      error   <= 1'b0;
      pwr_off <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          part_rst <= 1'b1;
          st       <= S_CLKSTOP;
        end
        S_CLKSTOP: begin
          part_clk_en <= 1'b0;
          cnt         <= '0;
          if (pwr_good) st <= S_CLKON;
          else begin
            pwr_req <= 1'b1;
            st      <= S_PWR;
          end
        end
        S_PWR: begin
          if (pwr_good) begin
            pwr_req <= 1'b0;
            st      <= S_CLKON;
          end else if (cnt == CW'(PWR_TMO - 1)) begin
            pwr_req <= 1'b0;
            st      <= S_UNDO_PWR;
          end else cnt <= cnt + 1'b1;
        end
        S_CLKON: begin
          part_clk_en <= 1'b1;
          cnt         <= '0;
          st          <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == CW'(SETTLE_CYC - 1)) begin
            clamp_req <= 1'b1;
            cnt       <= '0;
            st        <= S_UNCLAMP;
          end else cnt <= cnt + 1'b1;
        end
        S_UNCLAMP: begin
          if (clamp_ack) begin
            clamp_req <= 1'b0;
            st        <= S_RELEASE;
          end else if (cnt == CW'(CLAMP_TMO - 1)) begin
            clamp_req <= 1'b0;
            st        <= S_UNDO_CLK;
          end else cnt <= cnt + 1'b1;
        end
        S_RELEASE: begin
          part_rst <= 1'b0;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        S_UNDO_CLK: begin
          part_clk_en <= 1'b0;
          st          <= S_UNDO_PWR;
        end
        S_UNDO_PWR: begin
          part_rst <= 1'b1;
          pwr_off  <= 1'b1;
          error    <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module part_pwrup_seq_chk #(
  parameter int SETTLE_CYC = 2500,
  parameter int PWR_TMO    = 12500,
  parameter int CLAMP_TMO  = 12500
) (
  input logic clk,
  input logic rst_n,
  input logic part_rst,
  input logic part_clk_en,
  input logic pwr_req,
  input logic pwr_off,
  input logic clamp_req,
  input logic busy,
  input logic done,
  input logic error
);
  int unsigned ce_run, pr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_run <= 0;
      pr_run <= 0;
    end else begin
      ce_run <= part_clk_en ? ce_run + 1 : 0;
      pr_run <= pwr_req ? pr_run + 1 : 0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pwr_req && !clamp_req));
  assert_clk_off_for_pwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req |-> !part_clk_en);
  assert_pwr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req |-> (pr_run < PWR_TMO));
  assert_settle_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_req) |-> (ce_run >= SETTLE_CYC));
  assert_done_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!part_rst && part_clk_en && !clamp_req));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_error_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_rollback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (part_rst && pwr_off && !part_clk_en));
  assert_clamp_ctx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_req |-> (part_clk_en && part_rst));
endmodule

bind part_pwrup_seq part_pwrup_seq_chk #(
  .SETTLE_CYC(SETTLE_CYC), .PWR_TMO(PWR_TMO), .CLAMP_TMO(CLAMP_TMO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .part_rst(part_rst), .part_clk_en(part_clk_en),
  .pwr_req(pwr_req), .pwr_off(pwr_off), .clamp_req(clamp_req),
  .busy(busy), .done(done), .error(error)
);

// File: tb/tb_part_pwrup_seq.sv
module tb_part_pwrup_seq;
  localparam int SET = 20;
  localparam int PT  = 100;
  localparam int CT  = 50;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, pwr_good = 1'b0, clamp_ack = 1'b0;
  logic part_rst, part_clk_en, pwr_req, pwr_off, clamp_req, busy, done, error;

  part_pwrup_seq #(.SETTLE_CYC(SET), .PWR_TMO(PT), .CLAMP_TMO(CT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pwr_good(pwr_good),
    .clamp_ack(clamp_ack), .part_rst(part_rst), .part_clk_en(part_clk_en),
    .pwr_req(pwr_req), .pwr_off(pwr_off), .clamp_req(clamp_req),
    .busy(busy), .done(done), .error(error));

  int checks = 0, fails = 0, cyc = 0, res_cnt = 0, res_cyc = 0;
  int pwr_lat = -1, clamp_lat = -1, pcnt = 0, ccnt = 0;
  int pg_rise, ce_rise, ce_fall, cr_rise, pr_cnt, cr_cnt, viol;
  logic r_rst, r_ce, r_off, r_creq;
  logic ce_q = 0, cr_q = 0, d_q = 0, e_q = 0;
  int exp_q[$];
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (part_clk_en && !ce_q) ce_rise = cyc;
    if (!part_clk_en && ce_q) ce_fall = cyc;
    if (clamp_req && !cr_q) cr_rise = cyc;
    if (pwr_req) pr_cnt++;
    if (clamp_req) cr_cnt++;
    if (pwr_req && part_clk_en) viol++;
    if ((done && d_q) || (error && e_q)) chk(0, "R6 pulse width", 2, 1);
    if (done || error) begin
      int got;
      got = (done && error) ? 3 : (done ? 1 : 2);
      if (exp_q.size() == 0) chk(0, "R9 unexpected result", got, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(got == e, "R6 result kind", got, e);
      end
      r_rst = part_rst; r_ce = part_clk_en; r_off = pwr_off; r_creq = clamp_req;
      res_cyc = cyc;
      res_cnt++;
    end
    if (pwr_off) pwr_good = 1'b0;
    else if (pwr_req && pwr_lat >= 0 && !pwr_good) begin
      pcnt++;
      if (pcnt > pwr_lat) begin pwr_good = 1'b1; pg_rise = cyc; end
    end
    if (!pwr_req) pcnt = 0;
    if (clamp_req && clamp_lat >= 0) begin
      ccnt++;
      if (ccnt > clamp_lat) clamp_ack = 1'b1;
    end else begin
      ccnt = 0; clamp_ack = 1'b0;
    end
    ce_q = part_clk_en; cr_q = clamp_req; d_q = done; e_q = error;
  end

  task automatic run(input int exp, input int pl, input int cl, input bit restart);
    int n0, g;
    pwr_lat = pl; clamp_lat = cl;
    pg_rise = -1; ce_rise = -1; ce_fall = -1; cr_rise = -1;
    pr_cnt = 0; cr_cnt = 0; viol = 0;
    exp_q.push_back(exp);
    n0 = res_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(part_rst && busy, "R2 reset asserted after start", part_rst, 1);
    @(negedge clk);
    chk(!part_clk_en, "R2 clock stopped", part_clk_en, 0);
    if (restart) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    g = 0;
    while (res_cnt == n0 && g < 5000) begin @(negedge clk); g++; end
    if (g >= 5000) chk(0, "R6 no result (watchdog)", 0, 1);
    repeat (10) @(negedge clk);
    chk(res_cnt == n0 + 1, "R9 R6 exactly one result", res_cnt - n0, 1);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(part_rst && !part_clk_en && !pwr_req && !clamp_req && !pwr_off &&
        !busy && !done && !error, "R1 reset state", part_rst, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(part_rst && !busy, "R1 idle after reset", busy, 0);

    // normal power-up with a second start while busy
    run(1, 5, 3, 1'b1);
    chk(viol == 0, "R2 no power request with clock on", viol, 0);
    chk(pr_cnt > 0, "R3 power requested", pr_cnt, 1);
    chk(ce_rise - pg_rise == 2, "R4 clock after power-good", ce_rise - pg_rise, 2);
    chk(cr_rise - ce_rise == SET, "R4 settle time", cr_rise - ce_rise, SET);
    chk(!r_rst && r_ce && !r_creq, "R5 done state", r_rst, 0);

    // already powered: no power request
    run(1, 5, 0, 1'b1);
    chk(pr_cnt == 0, "R10 power step skipped", pr_cnt, 0);
    chk(cr_rise - ce_rise == SET, "R10 R4 settle time", cr_rise - ce_rise, SET);
    chk(!r_rst && r_ce, "R10 R5 completes", r_rst, 0);

    // clamp timeout: late rollback
    run(2, 5, -1, 1'b0);
    chk(cr_cnt == CT, "R8 clamp request window", cr_cnt, CT);
    chk(res_cyc - ce_fall == 1, "R8 clock off before error", res_cyc - ce_fall, 1);
    chk(r_rst && r_off && !r_ce, "R8 rollback state", r_off, 1);
    chk(!pwr_good, "R8 partition powered off", pwr_good, 0);

    // power timeout: early rollback
    run(2, -1, 3, 1'b0);
    chk(pr_cnt == PT, "R3 power request window", pr_cnt, PT);
    chk(ce_rise == -1, "R7 clock never enabled", ce_rise, -1);
    chk(r_rst && r_off && !r_ce, "R7 rollback state", r_off, 1);

    // recovery with fast responders
    run(1, 0, 0, 1'b0);
    chk(cr_rise - ce_rise == SET, "R4 settle time fast", cr_rise - ce_rise, SET);
    chk(!r_rst && r_ce, "R5 done after recovery", r_rst, 0);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_up();
  end
endmodule